// File: doc/BRIEF.md
# Video FIFO Transfer Scheduler

This block schedules the writes that a video display processor owes its memory. Each request joins a small circular queue of run-length descriptors. A descriptor holds a remaining slot count and the transfer type. The four request types are a CPU word write, a CPU byte write, a background fill and a background copy. On each memory access slot of a scanline, the head descriptor gives up one slot. A descriptor whose count reaches zero leaves the queue.

Requests of the same type as the queue tail fold into that tail. A CPU write that arrives behind a queued background transfer goes ahead of it. A count of pending CPU units drives the write stall towards the CPU. Background work never enters that count. A CPU read waits until the queue is fully empty, and then completes on the next usable slot.

Top module: `vfifo_sched`

## Requirements
- R1: During and straight after reset, every output is zero.
- R2: A request is accepted only when its unit count is nonzero and fewer than 7 descriptors are queued after this cycle's drain. A request that is not accepted leaves `q_used` and `pend_total` unchanged. `q_used` never exceeds 7.
- R3: `req_kind` encodes 0 as a CPU word write, 1 as a CPU byte write, 2 as a fill and 3 as a copy. The costs are one slot per unit for word writes and fills, and two slots per unit for byte writes and copies. Each enabled slot drains one slot from the head descriptor, which is removed when its count hits zero.
- R4: A request is folded into the tail descriptor, adding no entry, when the queue is non-empty and the tail has the same byte and background attributes.
- R5: A CPU write whose tail is a background descriptor is placed ahead of it. If that background descriptor was the only entry, the queue restarts as if from empty. Otherwise, the write may fold into the descriptor just before the background entry.
- R6: When a request starts an empty queue, the first slot drains on the 3rd enabled slot after the request cycle.
- R7: `pend_total` rises by the unit count of each accepted CPU write, and never for fills or copies. It falls by one per completed CPU unit, and a byte unit completes on its second slot.
- R8: `wr_stall` is high exactly while `pend_total` is greater than 4.
- R9: `rd_req` sets `rd_wait`. Once the queue is empty, the next enabled slot gives a one-cycle `rd_done` and clears `rd_wait`.
- R10: `dma_busy` rises with an accepted fill or copy. It falls the cycle after `q_used` is observed at zero with no new fill or copy. `fifo_run` is high exactly while `q_used` is nonzero.
- R11: A fill or copy request that arrives while `dma_busy` is high discards every queued descriptor and zeroes `pend_total`, then is queued on its own.
- R12: `line_start` resets the slot position and takes no slot that cycle. Only the first 16 slot strobes of a line are enabled, and unfinished work resumes after the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start of scanline, clears slot position |
| slot_tick | input | 1 | Memory access slot strobe |
| req_valid | input | 1 | Transfer request |
| req_kind | input | 2 | Request type (word, byte, fill, copy) |
| req_units | input | 8 | Units in the request |
| rd_req | input | 1 | CPU read request |
| wr_stall | output | 1 | CPU write stall |
| rd_wait | output | 1 | CPU read waiting |
| rd_done | output | 1 | CPU read completes this cycle |
| fifo_run | output | 1 | Queue holds work |
| dma_busy | output | 1 | Background transfer active |
| pend_total | output | 12 | Pending CPU units |
| q_used | output | 4 | Occupied descriptors |

## Verification
Requests, drains, flushes and folds all show on `q_used` and `pend_total` at the first edge after their cycle. `wr_stall` and `fifo_run` follow those same registers within the same cycle. The first drain comes three enabled slots after a start, and `rd_done` and the fall of `dma_busy` each come one edge after the queue is seen empty. The bench drives every input at the falling edge and advances its own model at the rising edge. It compares all outputs at the next falling edge, so each expected value is aligned with the edge that produces it.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;
  typedef enum logic [1:0] {
    K_WORD = 2'd0,
    K_BYTE = 2'd1,
    K_FILL = 2'd2,
    K_COPY = 2'd3
  } req_kind_e;

  function automatic logic kind_is_bg(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_double(input logic [1:0] k);
    return (k == K_BYTE) || (k == K_COPY);
  endfunction
endpackage

// File: rtl/vfifo_slot_timer.sv
module vfifo_slot_timer #(
  parameter int MAX_SLOT = 16,
  parameter int LAT      = 3,
  localparam int POS_W   = $clog2(MAX_SLOT + 1),
  localparam int LAT_W   = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic slot_tick,
  input  logic start,
  output logic slot_ok,
  output logic drain_ok
);
  logic [POS_W-1:0] pos_q, pos_n;
  logic [LAT_W-1:0] lat_q, lat_n;
  logic             pos_en, lat_en;

  assign slot_ok  = slot_tick && !line_start && (pos_q < POS_W'(MAX_SLOT));
  assign drain_ok = slot_ok && (lat_q == '0);

  always_comb begin
    pos_en = line_start || slot_ok;
    pos_n  = line_start ? '0 : pos_q + POS_W'(1);
    lat_en = start || (slot_ok && lat_q != '0);
    lat_n  = start ? LAT_W'(LAT - 1) : lat_q - LAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      lat_q <= '0;
    end else begin
      if (pos_en) pos_q <= pos_n;
      if (lat_en) lat_q <= lat_n;
    end
  end

  // R12: the position never passes the line length
  assert_pos_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(MAX_SLOT));
endmodule

// File: rtl/vfifo_desc_queue.sv
module vfifo_desc_queue
  import vfifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 12,
  parameter int UNIT_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int USE_W = IDX_W + 1,
  localparam int LIMIT = DEPTH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              drain_ok,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [UNIT_W-1:0] req_units,
  output logic [USE_W-1:0]  used,
  output logic              accept,
  output logic              start,
  output logic              fg_dec
);
  logic [CNT_W-1:0] cnt_q  [DEPTH];
  logic [CNT_W-1:0] cnt_n  [DEPTH];
  logic             byte_q [DEPTH];
  logic             byte_n [DEPTH];
  logic             bg_q   [DEPTH];
  logic             bg_n   [DEPTH];
  logic [IDX_W-1:0] head_q, head_n, tail, prev, slot;
  logic [USE_W-1:0] used_q, used_n;
  logic             pop, new_bg, new_byte;
  logic [CNT_W-1:0] new_cnt;

  assign used     = used_q;
  assign new_bg   = kind_is_bg(req_kind);
  assign new_byte = (req_kind == K_BYTE);
  assign new_cnt  = kind_double(req_kind) ? {CNT_W'(req_units), 1'b0} >> 0
                                          : CNT_W'(req_units);

  always_comb begin
    cnt_n  = cnt_q;
    byte_n = byte_q;
    bg_n   = bg_q;
    head_n = head_q;
    used_n = used_q;
    fg_dec = 1'b0;
    pop    = 1'b0;
    accept = 1'b0;
    start  = 1'b0;
    tail   = '0;
    prev   = '0;
    slot   = '0;
    if (flush) begin
      used_n = '0;
    end else if (drain_ok && used_q != '0) begin
      fg_dec = !bg_q[head_q] && (!byte_q[head_q] || cnt_q[head_q][0]);
      cnt_n[head_q] = cnt_q[head_q] - CNT_W'(1);
      if (cnt_q[head_q] == CNT_W'(1)) begin
        pop    = 1'b1;
        head_n = head_q + IDX_W'(1);
        used_n = used_q - USE_W'(1);
      end
    end
    if (req_valid && req_units != '0 && used_n < USE_W'(LIMIT)) begin
      accept = 1'b1;
      tail   = head_n + IDX_W'(used_n) - IDX_W'(1);
      prev   = tail - IDX_W'(1);
      slot   = head_n + IDX_W'(used_n);
      if (used_n != '0 && bg_n[tail] && !new_bg) begin
        if (used_n != USE_W'(1) && !bg_n[prev] && byte_n[prev] == new_byte) begin
          cnt_n[prev] = cnt_n[prev] + new_cnt;
        end else begin
          cnt_n[slot]  = cnt_n[tail];
          byte_n[slot] = byte_n[tail];
          bg_n[slot]   = bg_n[tail];
          cnt_n[tail]  = new_cnt;
          byte_n[tail] = new_byte;
          bg_n[tail]   = 1'b0;
          start        = (used_n == USE_W'(1));
          used_n       = used_n + USE_W'(1);
        end
      end else if (used_n != '0 && bg_n[tail] == new_bg && byte_n[tail] == new_byte) begin
        cnt_n[tail] = cnt_n[tail] + new_cnt;
      end else begin
        cnt_n[slot]  = new_cnt;
        byte_n[slot] = new_byte;
        bg_n[slot]   = new_bg;
        start        = (used_n == '0);
        used_n       = used_n + USE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      used_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i]  <= '0;
        byte_q[i] <= 1'b0;
        bg_q[i]   <= 1'b0;
      end
    end else begin
      head_q <= head_n;
      used_q <= used_n;
      cnt_q  <= cnt_n;
      byte_q <= byte_n;
      bg_q   <= bg_n;
    end
  end

  // R2: occupancy stays under the acceptance limit
  assert_used_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= USE_W'(LIMIT));

  // R3: a finished descriptor moves the head by one
  assert_pop_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> head_q == $past(head_q + IDX_W'(1)));
endmodule

// File: rtl/vfifo_status.sv
module vfifo_status
  import vfifo_pkg::*;
#(
  parameter int TOT_W     = 12,
  parameter int UNIT_W    = 8,
  parameter int STALL_LVL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [UNIT_W-1:0] req_units,
  input  logic              accept,
  input  logic              fg_dec,
  input  logic              q_empty,
  input  logic              slot_ok,
  input  logic              rd_req,
  output logic              flush,
  output logic [TOT_W-1:0]  pend_total,
  output logic              wr_stall,
  output logic              rd_wait,
  output logic              rd_done,
  output logic              dma_busy
);
  logic [TOT_W-1:0] tot_q, tot_n;
  logic             tot_en, busy_q, busy_n, rdw_q, rdw_n, done_q, done_n;
  logic             is_dma, dma_acc, cpu_acc;

  assign is_dma  = kind_is_bg(req_kind);
  assign flush   = req_valid && is_dma && busy_q;
  assign dma_acc = accept && is_dma;
  assign cpu_acc = accept && !is_dma;

  always_comb begin
    tot_en = flush || fg_dec || cpu_acc;
    tot_n  = flush ? '0 : tot_q;
    if (fg_dec)  tot_n = tot_n - TOT_W'(1);
    if (cpu_acc) tot_n = tot_n + TOT_W'(req_units);
    done_n = rdw_q && q_empty && slot_ok;
    rdw_n  = done_n ? 1'b0 : (rdw_q || rd_req);
    busy_n = dma_acc ? 1'b1 : (q_empty ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      busy_q <= 1'b0;
      rdw_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (tot_en) tot_q <= tot_n;
      busy_q <= busy_n;
      rdw_q  <= rdw_n;
      done_q <= done_n;
    end
  end

  assign pend_total = tot_q;
  assign wr_stall   = tot_q > TOT_W'(STALL_LVL);
  assign rd_wait    = rdw_q;
  assign rd_done    = done_q;
  assign dma_busy   = busy_q;

  // R7: without an accepted CPU write the pending count cannot grow
  assert_pend_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_acc |=> tot_q <= $past(tot_q));

  // R9: completion and waiting never overlap
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !rdw_q);

  // R10: busy only drops after an empty queue was seen
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(q_empty));
endmodule

// File: rtl/vfifo_sched.sv
module vfifo_sched #(
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 12,
  parameter int UNIT_W    = 8,
  parameter int TOT_W     = 12,
  parameter int STALL_LVL = 4,
  parameter int MAX_SLOT  = 16,
  parameter int LAT       = 3,
  localparam int USE_W    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              slot_tick,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [UNIT_W-1:0] req_units,
  input  logic              rd_req,
  output logic              wr_stall,
  output logic              rd_wait,
  output logic              rd_done,
  output logic              fifo_run,
  output logic              dma_busy,
  output logic [TOT_W-1:0]  pend_total,
  output logic [USE_W-1:0]  q_used
);
  logic rst_s1, rst_sync;
  logic slot_ok, drain_ok, start, accept, fg_dec, flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  vfifo_slot_timer #(.MAX_SLOT(MAX_SLOT), .LAT(LAT)) u_timer (
    .clk(clk), .rst_n(rst_sync), .line_start(line_start), .slot_tick(slot_tick),
    .start(start), .slot_ok(slot_ok), .drain_ok(drain_ok)
  );

  vfifo_desc_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_queue (
    .clk(clk), .rst_n(rst_sync), .flush(flush), .drain_ok(drain_ok),
    .req_valid(req_valid), .req_kind(req_kind), .req_units(req_units),
    .used(q_used), .accept(accept), .start(start), .fg_dec(fg_dec)
  );

  vfifo_status #(.TOT_W(TOT_W), .UNIT_W(UNIT_W), .STALL_LVL(STALL_LVL)) u_status (
    .clk(clk), .rst_n(rst_sync), .req_valid(req_valid), .req_kind(req_kind),
    .req_units(req_units), .accept(accept), .fg_dec(fg_dec),
    .q_empty(q_used == '0), .slot_ok(slot_ok), .rd_req(rd_req), .flush(flush),
    .pend_total(pend_total), .wr_stall(wr_stall), .rd_wait(rd_wait),
    .rd_done(rd_done), .dma_busy(dma_busy)
  );

  assign fifo_run = (q_used != '0);

  // R12: draining only happens on a real slot strobe outside a line start
  assert_drain_on_slot_R12: assert property (@(posedge clk) disable iff (!rst_sync)
    drain_ok |-> (slot_tick && !line_start));
endmodule

// File: tb/test_vfifo_sched.sv
`timescale 1ns/1ps
module test_vfifo_sched;
  localparam int MAXS = 16;
  localparam int LATC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0, slot_tick = 1'b0, req_valid = 1'b0, rd_req = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [7:0]  req_units = 8'd0;
  logic        wr_stall, rd_wait, rd_done, fifo_run, dma_busy;
  logic [11:0] pend_total;
  logic [3:0]  q_used;

  int nchk = 0, nfail = 0;

  int m_cnt[8];
  bit m_byte[8], m_bg[8];
  int m_head, m_used, m_lat, m_pos, m_tot;
  bit m_busy, m_rdw, m_done;

  always #2.5 clk = ~clk;

  vfifo_sched i_vfifo_sched (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .slot_tick(slot_tick),
    .req_valid(req_valid), .req_kind(req_kind), .req_units(req_units), .rd_req(rd_req),
    .wr_stall(wr_stall), .rd_wait(rd_wait), .rd_done(rd_done), .fifo_run(fifo_run),
    .dma_busy(dma_busy), .pend_total(pend_total), .q_used(q_used)
  );

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit same(int i, bit b, bit g);
    return (m_byte[i & 7] == b) && (m_bg[i & 7] == g);
  endfunction

  task automatic place(int i, int c, bit b, bit g);
    m_cnt[i & 7] = c; m_byte[i & 7] = b; m_bg[i & 7] = g;
  endtask

  // Reference model, advanced once per rising edge
  task automatic model(bit tk, bit ls, bit rv, logic [1:0] kd, int un, bit rd);
    bit flush, sok, emp_old, acc, start, dec, nb_byte, nb_bg;
    int nc, t;
    flush   = rv && kd[1] && m_busy;
    sok     = tk && !ls && (m_pos < MAXS);
    emp_old = (m_used == 0);
    acc = 0; start = 0; dec = 0;
    if (flush) m_used = 0;
    else if (sok && m_lat == 0 && m_used != 0) begin
      dec = !m_bg[m_head] && (!m_byte[m_head] || (m_cnt[m_head] % 2 == 1));
      m_cnt[m_head]--;
      if (m_cnt[m_head] == 0) begin m_head = (m_head + 1) & 7; m_used--; end
    end
    nb_byte = (kd == 2'd1);
    nb_bg   = kd[1];
    nc      = (kd == 2'd1 || kd == 2'd3) ? 2 * un : un;
    if (rv && un != 0 && m_used < 7) begin
      acc = 1;
      t = m_head + m_used - 1;
      if (m_used != 0 && m_bg[t & 7] && !nb_bg) begin
        if (m_used != 1 && same(t - 1, nb_byte, 1'b0)) m_cnt[(t - 1) & 7] += nc;
        else begin
          place(t + 1, m_cnt[t & 7], m_byte[t & 7], m_bg[t & 7]);
          place(t, nc, nb_byte, 1'b0);
          start = (m_used == 1);
          m_used++;
        end
      end else if (m_used != 0 && same(t, nb_byte, nb_bg)) m_cnt[t & 7] += nc;
      else begin
        place(m_head + m_used, nc, nb_byte, nb_bg);
        start = (m_used == 0);
        m_used++;
      end
    end
    if (flush) m_tot = 0;
    if (dec) m_tot--;
    if (acc && !nb_bg) m_tot += un;
    if (start) m_lat = LATC - 1;
    else if (sok && m_lat > 0) m_lat--;
    if (ls) m_pos = 0; else if (sok) m_pos++;
    m_done = m_rdw && emp_old && sok;
    m_rdw  = m_done ? 1'b0 : (m_rdw || rd);
    m_busy = (acc && nb_bg) ? 1'b1 : (emp_old ? 1'b0 : m_busy);
  endtask

  task automatic cmp_all();
    chk("R2 q_used", int'(q_used), m_used);
    chk("R7 pend_total", int'(pend_total), m_tot);
    chk("R8 wr_stall", int'(wr_stall), int'(m_tot > 4));
    chk("R9 rd_wait", int'(rd_wait), int'(m_rdw));
    chk("R9 rd_done", int'(rd_done), int'(m_done));
    chk("R10 dma_busy", int'(dma_busy), int'(m_busy));
    chk("R10 fifo_run", int'(fifo_run), int'(m_used != 0));
  endtask

  task automatic step(bit tk, bit ls, bit rv, logic [1:0] kd, int un, bit rd);
    slot_tick = tk; line_start = ls; req_valid = rv; req_kind = kd;
    req_units = 8'(un); rd_req = rd;
    @(posedge clk);
    model(tk, ls, rv, kd, un, rd);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 0, 0);
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 2'd0, 0, 0);
  endtask
  task automatic req(logic [1:0] kd, int un);
    step(0, 0, 1, kd, un, 0);
  endtask
  task automatic newline();
    step(0, 1, 0, 2'd0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
    $finish;
  end

  initial begin
    m_head = 0; m_used = 0; m_lat = 0; m_pos = 0; m_tot = 0;
    m_busy = 0; m_rdw = 0; m_done = 0;
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_byte[i] = 0; m_bg[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk("R1 reset q_used", int'(q_used), 0);
    chk("R1 reset pend_total", int'(pend_total), 0);
    chk("R1 reset flags", int'({wr_stall, rd_wait, rd_done, fifo_run, dma_busy}), 0);
    rst_n = 1'b1;
    idle(3);

    // R6 latency: word write, drains on third slot
    newline(); req(2'd0, 1); ticks(2);
    chk("R6 still queued", int'(q_used), 1);
    ticks(1);
    chk("R6 first drain", int'(q_used), 0);

    // R3 byte unit costs two slots, R7 counted on second
    newline(); req(2'd1, 1); ticks(3);
    chk("R3 byte half done", int'(q_used), 1);
    chk("R7 byte unit pending", int'(pend_total), 1);
    ticks(1);
    chk("R3 byte done", int'(q_used), 0);
    chk("R7 byte unit retired", int'(pend_total), 0);

    // R4 merge, R8 stall threshold
    newline(); req(2'd0, 2); req(2'd0, 3);
    chk("R4 merged words", int'(q_used), 1);
    chk("R8 stall above four", int'(wr_stall), 1);
    req(2'd1, 1);
    chk("R4 new type entry", int'(q_used), 2);
    ticks(3);
    chk("R8 five pending", int'(pend_total), 5);
    ticks(1);
    chk("R8 stall released at four", int'(wr_stall), 0);
    ticks(5);
    chk("R4 drained", int'(q_used), 0);

    // R5 CPU write jumps ahead of background fill
    newline(); req(2'd2, 4); req(2'd0, 1);
    chk("R5 two entries", int'(q_used), 2);
    ticks(3);
    chk("R5 cpu went first", int'(pend_total), 0);
    chk("R5 fill remains", int'(q_used), 1);
    ticks(4);
    chk("R10 empty run low", int'(fifo_run), 0);
    chk("R10 busy lags a cycle", int'(dma_busy), 1);
    idle(1);
    chk("R10 busy cleared", int'(dma_busy), 0);

    // R11 flush on DMA while busy
    newline(); req(2'd0, 2); req(2'd2, 3); req(2'd3, 1);
    chk("R11 flushed to one", int'(q_used), 1);
    chk("R11 pending zeroed", int'(pend_total), 0);
    ticks(4);
    chk("R11 copy two slots", int'(q_used), 0);
    idle(1);

    // R2 capacity of seven entries
    newline();
    for (int i = 0; i < 7; i++) req((i % 2 == 0) ? 2'd0 : 2'd1, 1);
    chk("R2 seven entries", int'(q_used), 7);
    req(2'd0, 1);
    chk("R2 eighth rejected", int'(q_used), 7);
    chk("R2 rejected not counted", int'(pend_total), 7);
    req(2'd3, 0);
    ticks(12);
    chk("R2 all drained", int'(q_used), 0);
    idle(1);

    // R12 line end limit
    newline(); ticks(13); req(2'd0, 5); ticks(5);
    chk("R12 only one slot left", int'(pend_total), 4);
    newline(); ticks(4);
    chk("R12 resumes next line", int'(pend_total), 0);

    // R9 read waits for empty queue
    newline(); req(2'd0, 2); step(0, 0, 0, 2'd0, 0, 1); ticks(4);
    chk("R9 waiting at empty", int'(rd_wait), 1);
    ticks(1);
    chk("R9 done pulse", int'(rd_done), 1);
    idle(1);
    chk("R9 pulse ends", int'(rd_done), 0);

    // Random phase
    void'($urandom(32'd4242));
    for (int c = 0; c < 4000; c++) begin
      bit tk, ls, rv, rd;
      tk = ($urandom_range(0, 1) == 1);
      ls = ($urandom_range(0, 29) == 0);
      rv = ($urandom_range(0, 4) == 0);
      rd = ($urandom_range(0, 39) == 0);
      step(tk, ls, rv, 2'($urandom_range(0, 3)), $urandom_range(0, 6), rd);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule